// File: doc/BRIEF.md
# Line Write-Enable Sequencer with Odd/Even Stream Split

This block sits at the output of a horizontal sample-rate converter and produces the write strobes for a field memory. It runs on the double-rate clock. The write-enable input and the converter's per-cycle step requests arrive alongside a half-rate enable. A rising write-enable input starts a line. Every sample slot the converter asks for then becomes one write pulse, so the output rate can reach twice the input sample rate. Cycles without a request leave the write enable low, which is how a lower rate is produced.

The block writes exactly the programmed number of samples on every line. If the input enable drops before the count is reached, it fills the rest of the line with dummy writes, one every clock cycle. If the count is reached first, it issues no more writes until the next line, even though the converter keeps stepping. Two configuration bits shift the input and output enable timing against their data. When splitting is on, even slots drive the main enable and odd slots drive a second enable. The odd stream drops its first slots and gains the same number of trailing dummy slots, so both streams carry the same count.

Top module: `lwe_line_seq`

## Requirements
- R1: After reset both `we_out` and `we_odd` are low, and they stay low until a line start is seen.
- R2: A line starts on the rising edge of the aligned write-enable input. The start clears the sample count, so every line, including one that follows another, is counted from zero.
- R3: Without splitting, a line produces exactly 4 × (`prog` + 1) pulses on `we_out`, whatever the request pattern.
- R4: While the aligned write-enable input is high, a slot is taken only in a cycle where `dto_req` is high. With `dto_req` held low, no pulse appears.
- R5: If the write-enable input falls before the count is met, dummy slots follow on consecutive clock cycles until the count is met.
- R6: Once the count is met, no enable is raised until the next line start, even if the write-enable input is still high and `dto_req` keeps firing.
- R7: With `in_shift` = 1 the write-enable input is delayed by one half-rate period (two clock cycles), so every output pulse comes two cycles later than with `in_shift` = 0.
- R8: With `out_shift` = 1 every output pulse comes one clock cycle earlier than with `out_shift` = 0.
- R9: With `split` = 1, even slots (0, 2, 4, …) pulse `we_out` and odd slots pulse `we_odd`. Each stream gets exactly 4 × (`prog` + 1) pulses, and the two enables are never high in the same cycle.
- R10: With `split` = 1 the first two odd slots are suppressed and the odd stream runs two slots past the even one. With continuous requests, the first and the last `we_odd` pulse each come 5 cycles after the first and the last `we_out` pulse.
- R11: With `split` = 0, `we_odd` stays low.
- R12: `wen_in` is sampled only in cycles where `half_en` is high. A pulse that lies wholly within cycles where `half_en` is low starts no line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_en | input | 1 | Marks the clock cycles of the half-rate input domain |
| wen_in | input | 1 | Write-enable input from the capture side |
| dto_req | input | 1 | Converter asks for one output sample this cycle |
| prog | input | 8 | Programmed line length, in units of 4 samples minus one |
| in_shift | input | 1 | Input enable leads its data by one half-rate period |
| out_shift | input | 1 | Output enables lead their data by one clock cycle |
| split | input | 1 | Enables the odd/even stream split |
| we_out | output | 1 | Write enable for the main (even) stream |
| we_odd | output | 1 | Write enable for the odd stream |

## Verification
The bench aims at the three ways a line can end: an input enable that drops early, one that stays high past the count, and one with no requests at all before the fall. A wrong fill or a wrong stop changes the pulse total, and fill pulses that are spread out instead of back to back show up as a gap. In split mode it measures the offset between the first and the last pulses of the two streams, so a wrong odd-stream skip or wrong trailing dummies move those offsets. It also compares pulse timing across both shift settings and sends a write-enable pulse that falls between half-rate cycles, which a design sampling on every clock would wrongly take as a line start.

// File: rtl/lwe_pkg.sv
package lwe_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_RUN  = 2'd1,
      SEQ_DONE = 2'd2
   } seq_state_e;

   typedef struct packed {
      logic vld;
      logic odd;
   } slot_t;

   localparam slot_t SLOT_NONE = '{vld: 1'b0, odd: 1'b0};

endpackage

// File: rtl/lwe_in_align.sv
module lwe_in_align #(
   parameter int IN_LEAD = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic half_en,
   input  logic wen_in,
   input  logic in_shift,
   output logic wen_al,
   output logic line_start
);

   localparam int DEPTH = IN_LEAD + 1;

   if (IN_LEAD < 1) begin : g_bad_lead
      $error("lwe_in_align: IN_LEAD must be at least 1");
   end

   logic [DEPTH-1:0] stg;
   logic             wen_al_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg[0] <= 1'b0;
      end else if (half_en) begin
         stg[0] <= wen_in;
      end
   end

   for (genvar i = 1; i < DEPTH; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stg[i] <= 1'b0;
         end else if (half_en) begin
            stg[i] <= stg[i-1];
         end
      end
   end

   assign wen_al = in_shift ? stg[DEPTH-1] : stg[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wen_al_d <= 1'b0;
      end else begin
         wen_al_d <= wen_al;
      end
   end

   assign line_start = wen_al & ~wen_al_d;

   // R12
   sample_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !half_en |=> $stable(stg[0]));

endmodule

// File: rtl/lwe_slot_seq.sv
module lwe_slot_seq
   import lwe_pkg::*;
#(
   parameter int CNT_W  = 8,
   parameter int UNIT   = 4,
   parameter int SKEW   = 2,
   parameter int SLOT_W = CNT_W + $clog2(UNIT) + 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             line_start,
   input  logic             wen_al,
   input  logic             dto_req,
   input  logic [CNT_W-1:0] prog,
   input  logic             split,
   output slot_t            slot_q
);

   if (UNIT < 1) begin : g_bad_unit
      $error("lwe_slot_seq: UNIT must be at least 1");
   end
   if (SKEW < 0) begin : g_bad_skew
      $error("lwe_slot_seq: SKEW must not be negative");
   end
   if (SLOT_W < CNT_W + $clog2(UNIT) + 2) begin : g_bad_width
      $error("lwe_slot_seq: SLOT_W too narrow for the doubled line");
   end

   seq_state_e        st;
   logic [SLOT_W-1:0] cnt;
   logic [SLOT_W-1:0] t_len;
   logic [SLOT_W-1:0] total;
   logic [SLOT_W-1:0] half;
   logic              advance;
   logic              last;
   slot_t             slot_d;

   assign t_len   = (SLOT_W'(prog) + SLOT_W'(1)) * SLOT_W'(UNIT);
   assign total   = split ? ((t_len + SLOT_W'(SKEW)) << 1) : t_len;
   assign advance = (st == SEQ_RUN) && (wen_al ? dto_req : 1'b1);
   assign last    = (cnt == total - SLOT_W'(1));
   assign half    = cnt >> 1;

   always_comb begin
      slot_d = SLOT_NONE;
      if (advance) begin
         if (!split) begin
            slot_d.vld = 1'b1;
         end else if (!cnt[0]) begin
            slot_d.vld = (half < t_len);
         end else begin
            slot_d.vld = (half >= SLOT_W'(SKEW));
            slot_d.odd = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= SEQ_IDLE;
         cnt <= '0;
      end else if (line_start) begin
         st  <= SEQ_RUN;
         cnt <= '0;
      end else if (advance) begin
         cnt <= cnt + SLOT_W'(1);
         if (last) begin
            st <= SEQ_DONE;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q <= SLOT_NONE;
      end else begin
         slot_q <= slot_d;
      end
   end

   // R2
   start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      line_start |=> (cnt == '0) && (st == SEQ_RUN));

   // R3
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == SEQ_RUN) |-> (cnt < total));

   // R4
   wait_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == SEQ_RUN && wen_al && !dto_req && !line_start) |=> (cnt == $past(cnt)));

   // R5
   drain_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == SEQ_RUN && !wen_al && !line_start) |=>
         ((cnt == $past(cnt) + SLOT_W'(1)) || (st == SEQ_DONE)));

   // R6
   done_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == SEQ_DONE && $past(st) == SEQ_DONE) |-> !slot_q.vld);

endmodule

// File: rtl/lwe_out_phase.sv
module lwe_out_phase
   import lwe_pkg::*;
#(
   parameter int OUT_LEAD = 1
) (
   input  logic  clk,
   input  logic  rst_n,
   input  slot_t slot_in,
   input  logic  out_shift,
   input  logic  split,
   output logic  we_out,
   output logic  we_odd
);

   if (OUT_LEAD < 1) begin : g_bad_lead
      $error("lwe_out_phase: OUT_LEAD must be at least 1");
   end

   slot_t pipe [OUT_LEAD+1];
   slot_t sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pipe[0] <= SLOT_NONE;
      end else begin
         pipe[0] <= slot_in;
      end
   end

   for (genvar i = 1; i <= OUT_LEAD; i++) begin : g_pipe
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pipe[i] <= SLOT_NONE;
         end else begin
            pipe[i] <= pipe[i-1];
         end
      end
   end

   assign sel    = out_shift ? pipe[0] : pipe[OUT_LEAD];
   assign we_out = sel.vld & ~sel.odd;
   assign we_odd = sel.vld & sel.odd;

   // R9
   excl_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(we_out && we_odd));

   // R11
   odd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!split && $past(!split) && $past(!split, 2) && $past(!split, 3)) |-> !we_odd);

endmodule

// File: rtl/lwe_line_seq.sv
module lwe_line_seq
   import lwe_pkg::*;
#(
   parameter int CNT_W    = 8,
   parameter int UNIT     = 4,
   parameter int SKEW     = 2,
   parameter int IN_LEAD  = 1,
   parameter int OUT_LEAD = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             half_en,
   input  logic             wen_in,
   input  logic             dto_req,
   input  logic [CNT_W-1:0] prog,
   input  logic             in_shift,
   input  logic             out_shift,
   input  logic             split,
   output logic             we_out,
   output logic             we_odd
);

   localparam int SLOT_W = CNT_W + $clog2(UNIT) + 3;

   logic  wen_al;
   logic  line_start;
   slot_t slot_q;

   lwe_in_align #(.IN_LEAD(IN_LEAD)) u_align (
      .clk        (clk),
      .rst_n      (rst_n),
      .half_en    (half_en),
      .wen_in     (wen_in),
      .in_shift   (in_shift),
      .wen_al     (wen_al),
      .line_start (line_start)
   );

   lwe_slot_seq #(
      .CNT_W  (CNT_W),
      .UNIT   (UNIT),
      .SKEW   (SKEW),
      .SLOT_W (SLOT_W)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_start (line_start),
      .wen_al     (wen_al),
      .dto_req    (dto_req),
      .prog       (prog),
      .split      (split),
      .slot_q     (slot_q)
   );

   lwe_out_phase #(.OUT_LEAD(OUT_LEAD)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .slot_in   (slot_q),
      .out_shift (out_shift),
      .split     (split),
      .we_out    (we_out),
      .we_odd    (we_odd)
   );

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |=> !we_out && !we_odd);

endmodule

// File: tb/sim_lwe_line_seq.sv
module sim_lwe_line_seq;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wen_in = 1'b0;
   logic [7:0] prog = 8'd2;
   logic       in_shift = 1'b0;
   logic       out_shift = 1'b0;
   logic       split = 1'b0;
   logic [1:0] req_mode = 2'd0;
   logic       half_en;
   logic       dto_req;
   logic       we_out;
   logic       we_odd;

   int cyc = 0;
   int n_chk = 0;
   int n_err = 0;
   int cnt_e, cnt_o, first_e, last_e, first_o, last_o, both;

   always #5 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;
   assign half_en = cyc[0];
   assign dto_req = (req_mode == 2'd1) | ((req_mode == 2'd2) & cyc[1]);

   lwe_line_seq u0 (
      .clk(clk), .rst_n(rst_n), .half_en(half_en), .wen_in(wen_in),
      .dto_req(dto_req), .prog(prog), .in_shift(in_shift),
      .out_shift(out_shift), .split(split), .we_out(we_out), .we_odd(we_odd)
   );

   always @(negedge clk) begin
      if (we_out) begin
         if (cnt_e == 0) first_e = cyc;
         last_e = cyc;
         cnt_e++;
      end
      if (we_odd) begin
         if (cnt_o == 0) first_o = cyc;
         last_o = cyc;
         cnt_o++;
      end
      if (we_out && we_odd) both++;
   end

   task automatic clear_mon();
      cnt_e = 0; cnt_o = 0; first_e = 0; last_e = 0;
      first_o = 0; last_o = 0; both = 0;
   endtask

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic sync_half(input bit want);
      @(negedge clk);
      while (half_en != want) @(negedge clk);
   endtask

   // runs one line; returns the cycle at which wen_in was raised
   task automatic run_line(input int hi, input int tail, output int t0);
      clear_mon();
      sync_half(1'b1);
      wen_in = 1'b1;
      t0 = cyc;
      wait_cyc(hi);
      sync_half(1'b1);
      wen_in = 1'b0;
      wait_cyc(tail);
   endtask

   task automatic t_reset();
      int t0;
      req_mode = 2'd1;
      clear_mon();
      wait_cyc(20);
      check(cnt_e == 0, "R1 no we_out before line start", cnt_e, 0);
      check(cnt_o == 0, "R1 no we_odd before line start", cnt_o, 0);
      t0 = 0;
   endtask

   task automatic t_count_late();
      int t0;
      prog = 8'd2; split = 1'b0; req_mode = 2'd1;
      run_line(60, 40, t0);
      check(cnt_e == 12, "R3 R6 late fall count", cnt_e, 12);
      check(cnt_o == 0, "R11 odd idle unsplit", cnt_o, 0);
      run_line(60, 40, t0);
      check(cnt_e == 12, "R2 second line recounted", cnt_e, 12);
   endtask

   task automatic t_no_req_drain();
      int t0, mid;
      prog = 8'd3; req_mode = 2'd0;
      clear_mon();
      sync_half(1'b1);
      wen_in = 1'b1;
      t0 = cyc;
      wait_cyc(30);
      mid = cnt_e;
      check(mid == 0, "R4 no pulse without request", mid, 0);
      sync_half(1'b1);
      wen_in = 1'b0;
      wait_cyc(60);
      check(cnt_e == 16, "R5 drain fills count", cnt_e, 16);
      check(last_e - first_e + 1 == 16, "R5 drain back to back", last_e - first_e + 1, 16);
   endtask

   task automatic t_sparse_early();
      int t0;
      prog = 8'd2; req_mode = 2'd2;
      run_line(10, 60, t0);
      check(cnt_e == 12, "R3 R5 sparse requests early fall", cnt_e, 12);
      req_mode = 2'd2;
      run_line(80, 40, t0);
      check(cnt_e == 12, "R3 sparse requests late fall", cnt_e, 12);
   endtask

   task automatic t_shifts();
      int t0, d0, d1, d2;
      prog = 8'd0; req_mode = 2'd1;
      in_shift = 1'b0; out_shift = 1'b0;
      run_line(20, 30, t0); d0 = first_e - t0;
      in_shift = 1'b1;
      run_line(20, 30, t0); d1 = first_e - t0;
      check(d1 - d0 == 2, "R7 input shift delay", d1 - d0, 2);
      in_shift = 1'b0; out_shift = 1'b1;
      run_line(20, 30, t0); d2 = first_e - t0;
      check(d0 - d2 == 1, "R8 output lead", d0 - d2, 1);
      check(cnt_e == 4, "R3 count with output lead", cnt_e, 4);
      out_shift = 1'b0;
   endtask

   task automatic t_split();
      int t0;
      prog = 8'd0; split = 1'b1; req_mode = 2'd1;
      run_line(40, 30, t0);
      check(cnt_e == 4, "R9 even stream count", cnt_e, 4);
      check(cnt_o == 4, "R9 odd stream count", cnt_o, 4);
      check(both == 0, "R9 enables exclusive", both, 0);
      check(first_o - first_e == 5, "R10 odd start skew", first_o - first_e, 5);
      check(last_o - last_e == 5, "R10 odd trailing dummies", last_o - last_e, 5);
      prog = 8'd1; req_mode = 2'd0;
      run_line(20, 60, t0);
      check(cnt_e == 8 && cnt_o == 8, "R9 R5 split drain counts", cnt_e + cnt_o, 16);
      split = 1'b0;
   endtask

   task automatic t_gap_pulse();
      prog = 8'd0; req_mode = 2'd1;
      clear_mon();
      sync_half(1'b0);
      wen_in = 1'b1;
      @(negedge clk);
      wen_in = 1'b0;
      wait_cyc(30);
      check(cnt_e == 0, "R12 pulse between samples ignored", cnt_e, 0);
   endtask

   initial begin
      wait_cyc(4);
      t_reset();
      rst_n = 1'b1;
      t_reset();
      t_count_late();
      t_no_req_drain();
      t_sparse_early();
      t_shifts();
      t_split();
      t_gap_pulse();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #200000;
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule